// File: doc/BRIEF.md
# Reloadable Timer with Compare Outputs

A 16-bit up-counter advanced by a machine-cycle enable. The enable pulses once per machine cycle, so a counter step takes many clocks. The counter has four sources of steps. It can run freely, at full or half machine-cycle rate. It can run only while a gate pin is high. It can count falling edges of the same pin as events. It can also be stopped. When the counter wraps from all ones to zero it raises an overflow flag. It can then reload from a 16-bit reload value. In another mode it reloads whenever a separate trigger pin falls.

Four compare channels watch the counter. A channel's compare event is any counter step or reload that leaves the counter equal to that channel's compare value. Each channel drives one output pin in one of two ways:
- **Set/clear mode:** the pin is set on a compare event and cleared on overflow. Software writes to the pin are locked out.
- **Shadow mode:** software writes go to a shadow bit, and that bit is copied to the pin only on a compare event.

A disabled channel passes software writes straight to its pin.

Top module: `tmr_cmp_unit`

## Requirements
- R1: After reset the counter is 0x0000, and all flags and all output pins are 0.
- R2: With `run_mode`=01 (timer), the counter rises by one on each `mc_tick`. With `div2`=1 it rises only on every second tick. The prescaler phase restarts on each counter write, so the second tick after a write is the first that counts.
- R3: With `run_mode`=10 (gated), a tick counts only if `cnt_pin` is 1 in that tick's cycle. `div2` applies as in R2.
- R4: With `run_mode`=11 (event), the counter rises by one for each tick at which `cnt_pin` is 0 and the sample taken at the previous tick was 1. A pin held steady never counts.
- R5: A step from 0xFFFF wraps the counter and sets `ovf_flag`. All flags stay set until a `flag_clr` pulse clears them.
- R6: With `rl_en`=1 and `rl_ext`=0, a wrap loads `reload_val` instead of 0x0000.
- R7: With `rl_en`=1 and `rl_ext`=1, a tick that sees `trig_pin` fall (1 then 0 on consecutive ticks) loads `reload_val`, and this load takes the place of that tick's increment. A falling trigger sets `ext_flag` only when `ext_flag_en`=1. With `rl_en`=0 the trigger pin causes no reload.
- R8: In set/clear mode (`cmp_mode` bit = 0, channel enabled), the pin goes to 1 one clock after a counter update that equals the channel's compare value. It goes to 0 after an overflow. If both happen on the same update, the pin goes to 0.
- R9: In set/clear mode a `latch_wr` does not change the pin.
- R10: In shadow mode (`cmp_mode` bit = 1), `latch_wr` stores `latch_data` in a shadow bit and leaves the pin unchanged. The next compare event copies the shadow bit to the pin.
- R11: An enabled channel's compare event sets its `match_flag` bit.
- R12: `cnt_wr` loads `cnt_wdata`, and this load has priority over any other counter update. With `run_mode`=00 the counter holds. A disabled channel's pin takes `latch_data` on `latch_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mc_tick | input | 1 | Machine-cycle enable, one pulse per machine cycle |
| run_mode | input | 2 | 00 stop, 01 timer, 10 gated, 11 event |
| div2 | input | 1 | Halves the timer/gated step rate |
| cnt_pin | input | 1 | Gate level or event input |
| trig_pin | input | 1 | External reload trigger |
| rl_en | input | 1 | Reload enable |
| rl_ext | input | 1 | 0: reload on wrap, 1: reload on trigger fall |
| ext_flag_en | input | 1 | Allows a trigger fall to set `ext_flag` |
| reload_val | input | 16 | Reload value |
| cnt_wr | input | 1 | Counter write strobe |
| cnt_wdata | input | 16 | Counter write value |
| cmp_vals | input | 64 | Compare values, channel i in bits [16i+15:16i] |
| cmp_en | input | 4 | Per-channel compare enable |
| cmp_mode | input | 4 | Per-channel mode: 0 set/clear, 1 shadow |
| latch_wr | input | 4 | Per-channel software latch write |
| latch_data | input | 4 | Per-channel latch write value |
| flag_clr | input | 1 | Clears every flag |
| count | output | 16 | Counter value |
| cmp_pin | output | 4 | Compare output pins |
| ovf_flag | output | 1 | Overflow flag |
| ext_flag | output | 1 | External trigger flag |
| match_flag | output | 4 | Per-channel compare flags |

## Verification
A table of counting scenarios runs each step source with steady, toggling and absent pin activity. These scenarios tell apart:
- full-rate from half-rate stepping;
- gated counting from blocked counting;
- true falling edges from steady levels.

Directed sequences then reach the cases that depend on order:
- a trigger fall in the same tick as an increment;
- a trigger fall with the flag disabled or with reload off;
- wrap-time reload;
- a compare of zero that coincides with overflow, where the clear must win;
- locked-out writes in set/clear mode and deferred writes in shadow mode.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    RUN_STOP  = 2'b00,
    RUN_TIMER = 2'b01,
    RUN_GATED = 2'b10,
    RUN_EVENT = 2'b11
  } run_mode_e;
endpackage

// File: rtl/tmr_stepgen.sv
module tmr_stepgen
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       mc_tick,
  input  logic [1:0] run_mode,
  input  logic       div2,
  input  logic       cnt_pin,
  input  logic       trig_pin,
  input  logic       restart,
  output logic       step,
  output logic       trig_fall
);
  logic cnt_prev, trig_prev, phase;
  logic cnt_fall, base_tg;

  always_comb begin
    cnt_fall  = mc_tick & cnt_prev & ~cnt_pin;
    trig_fall = mc_tick & trig_prev & ~trig_pin;
    case (run_mode_e'(run_mode))
      RUN_TIMER: base_tg = mc_tick;
      RUN_GATED: base_tg = mc_tick & cnt_pin;
      default:   base_tg = 1'b0;
    endcase
    step = (base_tg & (~div2 | phase)) |
           ((run_mode_e'(run_mode) == RUN_EVENT) & cnt_fall);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_prev  <= 1'b0;
      trig_prev <= 1'b0;
      phase     <= 1'b0;
    end else begin
      if (mc_tick) begin
        cnt_prev  <= cnt_pin;
        trig_prev <= trig_pin;
      end
      if (restart)             phase <= 1'b0;
      else if (base_tg & div2) phase <= ~phase;
    end
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic          trig_fall,
  input  logic          rl_en,
  input  logic          rl_ext,
  input  logic          ext_flag_en,
  input  logic [CW-1:0] reload_val,
  input  logic          wr,
  input  logic [CW-1:0] wdata,
  input  logic          flag_clr,
  output logic [CW-1:0] count,
  output logic          upd,
  output logic          ovf_pulse,
  output logic          ovf_flag,
  output logic          ext_flag
);
  localparam logic [CW-1:0] ALL_ONES = {CW{1'b1}};

  logic wrap, ext_load;

  always_comb begin
    wrap     = step & (count == ALL_ONES);
    ext_load = trig_fall & rl_en & rl_ext;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count     <= '0;
      upd       <= 1'b0;
      ovf_pulse <= 1'b0;
      ovf_flag  <= 1'b0;
      ext_flag  <= 1'b0;
    end else begin
      upd       <= 1'b0;
      ovf_pulse <= 1'b0;
      if (wr) begin
        count <= wdata;
      end else if (ext_load) begin
        count <= reload_val;
        upd   <= 1'b1;
      end else if (step) begin
        upd <= 1'b1;
        if (wrap) begin
          ovf_pulse <= 1'b1;
          count     <= (rl_en & ~rl_ext) ? reload_val : '0;
        end else begin
          count <= count + 1'b1;
        end
      end
      if (flag_clr)                       ovf_flag <= 1'b0;
      else if (wrap & ~wr & ~ext_load)    ovf_flag <= 1'b1;
      if (flag_clr)                       ext_flag <= 1'b0;
      else if (trig_fall & ext_flag_en)   ext_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/tmr_cmp_ch.sv
module tmr_cmp_ch #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] cmp_val,
  input  logic          en,
  input  logic          shadow_mode,
  input  logic          upd,
  input  logic          ovf_pulse,
  input  logic          wr,
  input  logic          wdata,
  input  logic          flag_clr,
  output logic          pin,
  output logic          flag
);
  logic shadow, hit;

  always_comb hit = upd & (count == cmp_val);

  always_ff @(posedge clk) begin
    if (rst) begin
      pin    <= 1'b0;
      shadow <= 1'b0;
      flag   <= 1'b0;
    end else begin
      if (wr) shadow <= wdata;
      if (!en) begin
        if (wr) pin <= wdata;
      end else if (!shadow_mode) begin
        if (ovf_pulse) pin <= 1'b0;
        else if (hit)  pin <= 1'b1;
      end else if (hit) begin
        pin <= shadow;
      end
      if (flag_clr)      flag <= 1'b0;
      else if (en & hit) flag <= 1'b1;
    end
  end
endmodule

// File: rtl/tmr_cmp_unit.sv
module tmr_cmp_unit #(
  parameter int CW  = 16,
  parameter int NCH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mc_tick,
  input  logic [1:0]        run_mode,
  input  logic              div2,
  input  logic              cnt_pin,
  input  logic              trig_pin,
  input  logic              rl_en,
  input  logic              rl_ext,
  input  logic              ext_flag_en,
  input  logic [CW-1:0]     reload_val,
  input  logic              cnt_wr,
  input  logic [CW-1:0]     cnt_wdata,
  input  logic [NCH*CW-1:0] cmp_vals,
  input  logic [NCH-1:0]    cmp_en,
  input  logic [NCH-1:0]    cmp_mode,
  input  logic [NCH-1:0]    latch_wr,
  input  logic [NCH-1:0]    latch_data,
  input  logic              flag_clr,
  output logic [CW-1:0]     count,
  output logic [NCH-1:0]    cmp_pin,
  output logic              ovf_flag,
  output logic              ext_flag,
  output logic [NCH-1:0]    match_flag
);
  logic step, trig_fall, upd, ovf_pulse;

  tmr_stepgen u_step (
    .clk(clk), .rst(rst), .mc_tick(mc_tick), .run_mode(run_mode),
    .div2(div2), .cnt_pin(cnt_pin), .trig_pin(trig_pin),
    .restart(cnt_wr), .step(step), .trig_fall(trig_fall)
  );

  tmr_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .step(step), .trig_fall(trig_fall),
    .rl_en(rl_en), .rl_ext(rl_ext), .ext_flag_en(ext_flag_en),
    .reload_val(reload_val), .wr(cnt_wr), .wdata(cnt_wdata),
    .flag_clr(flag_clr), .count(count), .upd(upd),
    .ovf_pulse(ovf_pulse), .ovf_flag(ovf_flag), .ext_flag(ext_flag)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    tmr_cmp_ch #(.CW(CW)) u_ch (
      .clk(clk), .rst(rst), .count(count),
      .cmp_val(cmp_vals[i*CW +: CW]), .en(cmp_en[i]),
      .shadow_mode(cmp_mode[i]), .upd(upd), .ovf_pulse(ovf_pulse),
      .wr(latch_wr[i]), .wdata(latch_data[i]), .flag_clr(flag_clr),
      .pin(cmp_pin[i]), .flag(match_flag[i])
    );
  end
endmodule

// File: rtl/tmr_cmp_chk.sv
module tmr_cmp_chk #(
  parameter int CW  = 16,
  parameter int NCH = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              mc_tick,
  input logic              cnt_wr,
  input logic              ext_flag_en,
  input logic              flag_clr,
  input logic [NCH*CW-1:0] cmp_vals,
  input logic [NCH-1:0]    cmp_en,
  input logic [NCH-1:0]    cmp_mode,
  input logic [CW-1:0]     count,
  input logic [NCH-1:0]    cmp_pin,
  input logic              ovf_flag,
  input logic              ext_flag,
  input logic [NCH-1:0]    match_flag
);
  // R12 / R2: the counter moves only after a tick or a write
  assert_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (!$past(mc_tick) && !$past(cnt_wr)) |-> $stable(count));

  // R5: overflow flag rises only when the counter was all ones
  assert_ovf_src_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_flag) |-> ($past(count) == {CW{1'b1}}));

  // R7: external flag rises only when enabled
  assert_ext_en_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(ext_flag) |-> $past(ext_flag_en));

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    // R8: in set/clear mode the pin rises only on a compare hit
    assert_set_on_match_R8: assert property (@(posedge clk) disable iff (rst)
      ($rose(cmp_pin[i]) && $past(cmp_en[i]) && !$past(cmp_mode[i]))
        |-> ($past(count) == $past(cmp_vals[i*CW +: CW])));
    // R11: match flag rises only with an equal counter
    assert_match_flag_R11: assert property (@(posedge clk) disable iff (rst)
      $rose(match_flag[i]) |-> ($past(count) == $past(cmp_vals[i*CW +: CW])));
  end
endmodule

bind tmr_cmp_unit tmr_cmp_chk #(.CW(CW), .NCH(NCH)) u_chk (
  .clk(clk), .rst(rst), .mc_tick(mc_tick), .cnt_wr(cnt_wr),
  .ext_flag_en(ext_flag_en), .flag_clr(flag_clr), .cmp_vals(cmp_vals),
  .cmp_en(cmp_en), .cmp_mode(cmp_mode), .count(count), .cmp_pin(cmp_pin),
  .ovf_flag(ovf_flag), .ext_flag(ext_flag), .match_flag(match_flag)
);

// File: tb/sim_tmr_cmp_unit.sv
module sim_tmr_cmp_unit;
  localparam int CW = 16;
  localparam int NCH = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mc_tick = 1'b0;
  logic [1:0] run_mode = 2'b00;
  logic div2 = 1'b0, cnt_pin = 1'b0, trig_pin = 1'b0;
  logic rl_en = 1'b0, rl_ext = 1'b0, ext_flag_en = 1'b0;
  logic [CW-1:0] reload_val = '0;
  logic cnt_wr = 1'b0;
  logic [CW-1:0] cnt_wdata = '0;
  logic [NCH*CW-1:0] cmp_vals = '0;
  logic [NCH-1:0] cmp_en = '0, cmp_mode = '0, latch_wr = '0, latch_data = '0;
  logic flag_clr = 1'b0;
  logic [CW-1:0] count;
  logic [NCH-1:0] cmp_pin, match_flag;
  logic ovf_flag, ext_flag;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tmr_cmp_unit #(.CW(CW), .NCH(NCH)) u0 (.*);

  typedef struct packed {
    logic [1:0]  mode;
    logic        dv;
    logic        tog;
    logic        lvl;
    logic [15:0] start;
    logic [7:0]  n;
    logic [15:0] exp;
    logic        ovf;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{2'b01, 1'b0, 1'b0, 1'b0, 16'h0010, 8'd5, 16'h0015, 1'b0},
    '{2'b01, 1'b1, 1'b0, 1'b0, 16'h0100, 8'd6, 16'h0103, 1'b0},
    '{2'b01, 1'b1, 1'b0, 1'b0, 16'h0100, 8'd5, 16'h0102, 1'b0},
    '{2'b10, 1'b0, 1'b0, 1'b1, 16'h2000, 8'd4, 16'h2004, 1'b0},
    '{2'b10, 1'b0, 1'b0, 1'b0, 16'h2000, 8'd4, 16'h2000, 1'b0},
    '{2'b10, 1'b1, 1'b0, 1'b1, 16'h2000, 8'd4, 16'h2002, 1'b0},
    '{2'b11, 1'b0, 1'b1, 1'b1, 16'h0050, 8'd6, 16'h0053, 1'b0},
    '{2'b11, 1'b0, 1'b1, 1'b0, 16'h0050, 8'd5, 16'h0052, 1'b0},
    '{2'b11, 1'b0, 1'b0, 1'b1, 16'h0050, 8'd6, 16'h0050, 1'b0},
    '{2'b01, 1'b0, 1'b0, 1'b0, 16'hFFFE, 8'd3, 16'h0001, 1'b1},
    '{2'b00, 1'b0, 1'b0, 1'b0, 16'h0777, 8'd4, 16'h0777, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) mc_tick = 1'b1;
    @(negedge clk) mc_tick = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic write_cnt(input logic [CW-1:0] v);
    @(negedge clk) begin cnt_wr = 1'b1; cnt_wdata = v; end
    @(negedge clk) cnt_wr = 1'b0;
  endtask

  task automatic clear_flags();
    @(negedge clk) flag_clr = 1'b1;
    @(negedge clk) flag_clr = 1'b0;
  endtask

  task automatic latch(input int ch, input logic v);
    @(negedge clk) begin latch_wr[ch] = 1'b1; latch_data[ch] = v; end
    @(negedge clk) latch_wr = '0;
    @(negedge clk);
  endtask

  function automatic string mode_req(input logic [1:0] m);
    case (m)
      2'b01: return "R2 timer";
      2'b10: return "R3 gated";
      2'b11: return "R4 event";
      default: return "R12 stop";
    endcase
  endfunction

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    end
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 count", count, 0);
    check("R1 flags", {ovf_flag, ext_flag, match_flag}, 0);
    check("R1 pins", cmp_pin, 0);

    for (int v = 0; v < NV; v++) begin
      run_mode = 2'b00;
      cnt_pin = VECS[v].lvl;
      tick();
      clear_flags();
      write_cnt(VECS[v].start);
      run_mode = VECS[v].mode;
      div2 = VECS[v].dv;
      for (int i = 0; i < int'(VECS[v].n); i++) begin
        cnt_pin = VECS[v].tog ? (VECS[v].lvl ^ ~i[0]) : VECS[v].lvl;
        tick();
      end
      check(mode_req(VECS[v].mode), count, VECS[v].exp);
      check("R5 overflow flag", ovf_flag, VECS[v].ovf);
    end
    div2 = 1'b0;
    run_mode = 2'b00;
    clear_flags();
    check("R5 flag clear", ovf_flag, 0);

    // R6 reload on wrap
    reload_val = 16'h1234; rl_en = 1'b1; rl_ext = 1'b0;
    write_cnt(16'hFFFF);
    run_mode = 2'b01;
    tick();
    check("R6 wrap reload", count, 16'h1234);
    check("R6 overflow flag", ovf_flag, 1);

    // R7 trigger reload replaces the increment
    run_mode = 2'b00; rl_ext = 1'b1; ext_flag_en = 1'b1;
    clear_flags();
    write_cnt(16'h0005);
    run_mode = 2'b01;
    trig_pin = 1'b1; tick();
    check("R7 count before fall", count, 16'h0006);
    trig_pin = 1'b0; tick();
    check("R7 trigger reload", count, 16'h1234);
    check("R7 ext flag set", ext_flag, 1);
    clear_flags();
    ext_flag_en = 1'b0;
    trig_pin = 1'b1; tick();
    trig_pin = 1'b0; tick();
    check("R7 reload flag disabled", count, 16'h1234);
    check("R7 ext flag stays clear", ext_flag, 0);
    rl_en = 1'b0;
    trig_pin = 1'b1; tick();
    trig_pin = 1'b0; tick();
    check("R7 no reload when off", count, 16'h1236);
    rl_ext = 1'b0;

    // R8 / R9 / R11 set/clear mode on channel 0
    run_mode = 2'b00;
    clear_flags();
    cmp_vals[0 +: CW] = 16'h0003; cmp_mode[0] = 1'b0; cmp_en[0] = 1'b1;
    write_cnt(16'h0001);
    run_mode = 2'b01;
    tick();
    check("R8 pin low before match", cmp_pin[0], 0);
    tick();
    check("R8 pin set on match", cmp_pin[0], 1);
    check("R11 match flag", match_flag[0], 1);
    latch(0, 1'b0);
    check("R9 write ignored", cmp_pin[0], 1);
    write_cnt(16'hFFFE);
    tick();
    check("R8 pin held", cmp_pin[0], 1);
    tick();
    check("R8 pin cleared on overflow", cmp_pin[0], 0);

    // R12 disabled channel follows writes; R8 overflow beats match
    run_mode = 2'b00;
    cmp_vals[CW +: CW] = 16'h0000; cmp_mode[1] = 1'b0;
    latch(1, 1'b1);
    check("R12 disabled pin follows write", cmp_pin[1], 1);
    cmp_en[1] = 1'b1;
    write_cnt(16'hFFFF);
    run_mode = 2'b01;
    tick();
    check("R8 overflow wins over match", cmp_pin[1], 0);

    // R10 shadow mode on channel 2
    run_mode = 2'b00;
    clear_flags();
    cmp_vals[2*CW +: CW] = 16'h0010; cmp_mode[2] = 1'b1; cmp_en[2] = 1'b1;
    write_cnt(16'h000E);
    latch(2, 1'b1);
    check("R10 write deferred", cmp_pin[2], 0);
    run_mode = 2'b01;
    tick();
    check("R10 pin before match", cmp_pin[2], 0);
    tick();
    check("R10 shadow copied on match", cmp_pin[2], 1);
    check("R11 shadow channel flag", match_flag[2], 1);
    clear_flags();
    check("R5 match flags cleared", match_flag, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule